// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block translates 32-bit effective addresses into physical addresses using a small fully associative table of cached translations. Each of the 32 entries describes one page, and each entry picks its own page size from four choices: 4 KB, 16 KB, 512 KB or 8 MB. The page size sets how many upper address bits take part in the match and how many low bits pass through untranslated. A lookup compares the effective page number and the current 4-bit address-space identifier against every entry at once. It returns a registered hit flag, the physical address and the 4-bit protection-group number of the matching entry.

Entries are loaded through a write port. A write either names its target slot or goes to a round-robin replacement slot. An invalidate port clears one slot, every non-global entry of one address space, or the whole table, each in a single cycle. Misses are reported and nothing more: table walking, permission checks and cache effects belong to the surrounding logic.

Top module: `xtlb`

## Requirements
- R1: After reset every entry is invalid, the round-robin slot is 0, and `rsp_valid`, `rsp_hit` and `rsp_multi` are 0.
- R2: A request presented with `lk_valid` high at a clock edge produces `rsp_valid` high, together with its hit flag, address and group, in the following cycle. Without a request `rsp_valid` is low.
- R3: The 2-bit size code selects which address bits are compared: 0 selects 4 KB (bits 31..12), 1 selects 16 KB (bits 31..14), 2 selects 512 KB (bits 31..19) and 3 selects 8 MB (bits 31..23).
- R4: On a hit, `rsp_pa` takes the entry's physical page bits above the page boundary and the request's effective-address bits below it. Stored physical bits below the boundary are ignored.
- R5: A non-global entry hits only when its address-space ID equals `lk_asid`. An entry written with `wr_global` set hits for any `lk_asid`.
- R6: On a hit, `rsp_group` shows the entry's group number. On a miss, `rsp_hit`, `rsp_pa` and `rsp_group` are all 0.
- R7: When several valid entries match, the lowest-numbered one supplies the result and `rsp_multi` is 1. With a single match `rsp_multi` is 0.
- R8: A write with `wr_use_idx` set loads slot `wr_idx`. The new entry is valid from the next cycle onward.
- R9: A write with `wr_use_idx` clear loads the round-robin slot. The slot then advances by one and wraps from 31 to 0. Indexed writes leave the slot unchanged.
- R10: `inv_op` = 1 clears only slot `inv_idx`.
- R11: `inv_op` = 2 clears every non-global entry whose address-space ID equals `inv_asid`. Global entries and other address spaces are kept.
- R12: `inv_op` = 3 clears every entry.
- R13: A write in the same cycle as any invalidate (`inv_op` not 0) is dropped and does not advance the round-robin slot. A lookup in the same cycle as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_asid | input | 4 | Current address-space ID |
| rsp_valid | output | 1 | Registered: a lookup result is present |
| rsp_hit | output | 1 | Registered: the lookup matched an entry |
| rsp_multi | output | 1 | Registered: more than one entry matched |
| rsp_pa | output | 32 | Registered physical address (0 on miss) |
| rsp_group | output | 4 | Registered protection group (0 on miss) |
| wr_en | input | 1 | Entry write strobe |
| wr_use_idx | input | 1 | 1: write to `wr_idx`; 0: write to round-robin slot |
| wr_idx | input | 5 | Explicit target slot |
| wr_epn | input | 20 | Effective page number (address bits 31..12) |
| wr_ppn | input | 20 | Physical page number (address bits 31..12) |
| wr_size | input | 2 | Page-size code |
| wr_asid | input | 4 | Address-space ID of the entry |
| wr_global | input | 1 | Entry ignores the address-space ID |
| wr_group | input | 4 | Protection group of the entry |
| inv_op | input | 2 | 0 none, 1 one slot, 2 by address space, 3 all |
| inv_idx | input | 5 | Slot cleared when `inv_op` = 1 |
| inv_asid | input | 4 | Address space cleared when `inv_op` = 2 |

## Verification
The assertions assume that `wr_idx` and `inv_idx` always name an existing slot. They also assume the request and control inputs are stable around each rising edge, so that one request maps to one registered response. The bench drives every input just after a falling edge and uses only slot numbers from 0 to 31. It keeps write and invalidate apart, except in the one scenario that deliberately collides them to check the drop rule. Entries that are meant to be distinct use page numbers and address spaces chosen so they cannot overlap unless a test asks for a multiple match.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned BASE_SHIFT = 12;
  localparam int unsigned PN_W = ADDR_W - BASE_SHIFT;
  localparam int unsigned ASID_W = 4;
  localparam int unsigned GRP_W = 4;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_16K  = 2'd1,
    PG_512K = 2'd2,
    PG_8M   = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ONE  = 2'd1,
    INV_ASID = 2'd2,
    INV_ALL  = 2'd3
  } inv_op_e;

  typedef struct packed {
    logic                 valid;
    logic                 glob;
    pg_size_e             size;
    logic [ASID_W-1:0]    asid;
    logic [GRP_W-1:0]     grp;
    logic [PN_W-1:0]      epn;
    logic [PN_W-1:0]      ppn;
  } tlb_ent_t;

  // Page-number bits that take part in the compare for a size code.
  function automatic logic [PN_W-1:0] pn_mask(pg_size_e s);
    logic [PN_W-1:0] m;
    case (s)
      PG_4K:   m = {PN_W{1'b1}};
      PG_16K:  m = {PN_W{1'b1}} << 2;
      PG_512K: m = {PN_W{1'b1}} << 7;
      default: m = {PN_W{1'b1}} << 11;
    endcase
    return m;
  endfunction

  // Physical page above the boundary, effective offset below it.
  function automatic logic [ADDR_W-1:0] pa_merge(logic [PN_W-1:0] ppn,
                                                 logic [ADDR_W-1:0] ea,
                                                 pg_size_e s);
    logic [PN_W-1:0] m;
    logic [PN_W-1:0] hi;
    m  = pn_mask(s);
    hi = (ppn & m) | (ea[ADDR_W-1:BASE_SHIFT] & ~m);
    return {hi, ea[BASE_SHIFT-1:0]};
  endfunction

endpackage

// File: rtl/xtlb_match.sv
module xtlb_match
  import xtlb_pkg::*;
(
  input  tlb_ent_t          ent,
  input  logic [PN_W-1:0]   ea_pn,
  input  logic [ASID_W-1:0] asid,
  output logic              hit
);
  logic page_eq;
  logic space_eq;

  assign page_eq  = (((ent.epn ^ ea_pn) & pn_mask(ent.size)) == '0);
  assign space_eq = ent.glob || (ent.asid == asid);
  assign hit      = ent.valid && page_eq && space_eq;
endmodule

// File: rtl/xtlb_prio.sv
module xtlb_prio #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  match,
  output logic          any,
  output logic          multi,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IW'(i);
    end
  end

  assign any   = |match;
  assign multi = |(match & (match - 1'b1));

  // R7: a multiple match is always also a match
  a_r7_multi_implies_any: assert property (@(posedge clk) disable iff (!rst_n)
    multi |-> any);

  // R7: the chosen slot is one of the matching slots
  a_r7_idx_is_match: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> match[idx]);
endmodule

// File: rtl/xtlb.sv
module xtlb
  import xtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_ea,
  input  logic [ASID_W-1:0]    lk_asid,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_multi,
  output logic [ADDR_W-1:0]    rsp_pa,
  output logic [GRP_W-1:0]     rsp_group,
  input  logic                 wr_en,
  input  logic                 wr_use_idx,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [PN_W-1:0]      wr_epn,
  input  logic [PN_W-1:0]      wr_ppn,
  input  logic [1:0]           wr_size,
  input  logic [ASID_W-1:0]    wr_asid,
  input  logic                 wr_global,
  input  logic [GRP_W-1:0]     wr_group,
  input  logic [1:0]           inv_op,
  input  logic [IDX_W-1:0]     inv_idx,
  input  logic [ASID_W-1:0]    inv_asid
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  tlb_ent_t           ent_q [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic               any_hit;
  logic               any_multi;
  logic [IDX_W-1:0]   sel_idx;

  // Named internal events
  inv_op_e            inv_kind;
  logic               wr_ok;
  logic               rr_step;
  logic [IDX_W-1:0]   wr_tgt;
  tlb_ent_t           new_ent;

  assign inv_kind = inv_op_e'(inv_op);
  assign wr_ok    = wr_en && (inv_kind == INV_NONE);
  assign rr_step  = wr_ok && !wr_use_idx;
  assign wr_tgt   = wr_use_idx ? wr_idx : rr_ptr;

  always_comb begin
    new_ent.valid = 1'b1;
    new_ent.glob  = wr_global;
    new_ent.size  = pg_size_e'(wr_size);
    new_ent.asid  = wr_asid;
    new_ent.grp   = wr_group;
    new_ent.epn   = wr_epn;
    new_ent.ppn   = wr_ppn;
  end

  // Parallel compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign valid_vec[g] = ent_q[g].valid;
    xtlb_match u_match (
      .ent   (ent_q[g]),
      .ea_pn (lk_ea[ADDR_W-1:BASE_SHIFT]),
      .asid  (lk_asid),
      .hit   (match_vec[g])
    );
  end

  xtlb_prio #(.N(ENTRIES)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .match (match_vec),
    .any   (any_hit),
    .multi (any_multi),
    .idx   (sel_idx)
  );

  // Table storage: invalidate takes precedence, a colliding write is dropped
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else begin
        case (inv_kind)
          INV_ONE:  if (inv_idx == IDX_W'(i)) ent_q[i].valid <= 1'b0;
          INV_ASID: if (!ent_q[i].glob && ent_q[i].asid == inv_asid)
                      ent_q[i].valid <= 1'b0;
          INV_ALL:  ent_q[i].valid <= 1'b0;
          default:  if (wr_ok && wr_tgt == IDX_W'(i)) ent_q[i] <= new_ent;
        endcase
      end
    end
  end

  // Round-robin replacement slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (rr_step) begin
      rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_group <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_multi <= lk_valid && any_multi;
      if (lk_valid && any_hit) begin
        rsp_pa    <= pa_merge(ent_q[sel_idx].ppn, lk_ea, ent_q[sel_idx].size);
        rsp_group <= ent_q[sel_idx].grp;
      end else begin
        rsp_pa    <= '0;
        rsp_group <= '0;
      end
    end
  end

  // R2: a response follows every request by one cycle
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R6: a miss carries no address and no group
  a_r6_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_pa == '0 && rsp_group == '0));

  // R7: the multiple-match flag needs a hit
  a_r7_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);

  // R9: the replacement slot steps by one unless it wraps
  a_r9_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_step && rr_ptr != LAST) |=> rr_ptr == $past(rr_ptr) + 1'b1);
  a_r9_rr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_step && rr_ptr == LAST) |=> rr_ptr == '0);

  // R10: the named slot is invalid after a single-slot invalidate
  a_r10_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_kind == INV_ONE) |=> !valid_vec[$past(inv_idx)]);

  // R12: nothing is valid after a full invalidate
  a_r12_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_kind == INV_ALL) |=> valid_vec == '0);

  // R13: a write colliding with an invalidate leaves the slot pointer alone
  a_r13_drop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inv_kind != INV_NONE) |=> $stable(rr_ptr));
endmodule

// File: tb/xtlb_bench.sv
module xtlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ea = '0;
  logic [3:0]  lk_asid = '0;
  logic        rsp_valid, rsp_hit, rsp_multi;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_group;
  logic        wr_en = 1'b0;
  logic        wr_use_idx = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [19:0] wr_epn = '0;
  logic [19:0] wr_ppn = '0;
  logic [1:0]  wr_size = '0;
  logic [3:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [3:0]  wr_group = '0;
  logic [1:0]  inv_op = '0;
  logic [4:0]  inv_idx = '0;
  logic [3:0]  inv_asid = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  xtlb u_xtlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_asid(lk_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
    .rsp_pa(rsp_pa), .rsp_group(rsp_group),
    .wr_en(wr_en), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx),
    .wr_epn(wr_epn), .wr_ppn(wr_ppn), .wr_size(wr_size),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_group(wr_group),
    .inv_op(inv_op), .inv_idx(inv_idx), .inv_asid(inv_asid)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Offset width for a size code, restated from the requirement
  function automatic int off_bits(logic [1:0] sz);
    case (sz)
      2'd0: return 12;
      2'd1: return 14;
      2'd2: return 19;
      default: return 23;
    endcase
  endfunction

  function automatic logic [31:0] want_pa(logic [31:0] pbase, logic [31:0] ea,
                                          logic [1:0] sz);
    logic [31:0] low;
    low = (32'h1 << off_bits(sz)) - 32'h1;
    return (pbase & ~low) | (ea & low);
  endfunction

  task automatic wr(bit use_idx, logic [4:0] idx, logic [31:0] ebase,
                    logic [31:0] pbase, logic [1:0] sz, logic [3:0] asid,
                    bit glob, logic [3:0] grp);
    wr_en = 1'b1; wr_use_idx = use_idx; wr_idx = idx;
    wr_epn = ebase[31:12]; wr_ppn = pbase[31:12]; wr_size = sz;
    wr_asid = asid; wr_global = glob; wr_group = grp;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic inv(logic [1:0] op, logic [4:0] idx, logic [3:0] asid);
    inv_op = op; inv_idx = idx; inv_asid = asid;
    @(negedge clk);
    inv_op = 2'd0;
  endtask

  task automatic look(string req, logic [31:0] ea, logic [3:0] asid, bit hit,
                      logic [31:0] pa, logic [3:0] grp, bit multi);
    lk_valid = 1'b1; lk_ea = ea; lk_asid = asid;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk(req, "rsp_hit", {31'b0, rsp_hit}, {31'b0, hit});
    chk(req, "rsp_pa", rsp_pa, hit ? pa : 32'h0);
    chk(req, "rsp_group", {28'b0, rsp_group}, hit ? {28'b0, grp} : 32'h0);
    chk(req, "rsp_multi", {31'b0, rsp_multi}, {31'b0, multi});
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "rsp_hit", {31'b0, rsp_hit}, 32'd0);
    chk("R1", "rsp_multi", {31'b0, rsp_multi}, 32'd0);
    look("R1", 32'h0000_0000, 4'd0, 1'b0, 32'h0, 4'd0, 1'b0);
    @(negedge clk);
    chk("R2", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_sizes();
    wr(1'b1, 5'd3, 32'h1234_5000, 32'hABCD_E000, 2'd0, 4'd2, 1'b0, 4'd5);
    look("R8", 32'h1234_5678, 4'd2, 1'b1, 32'hABCD_E678, 4'd5, 1'b0);
    look("R3", 32'h1234_6000, 4'd2, 1'b0, 32'h0, 4'd0, 1'b0);
    wr(1'b1, 5'd4, 32'h4000_0000, 32'h8000_6000, 2'd1, 4'd3, 1'b0, 4'd9);
    look("R4", 32'h4000_1ABC, 4'd3, 1'b1,
         want_pa(32'h8000_6000, 32'h4000_1ABC, 2'd1), 4'd9, 1'b0);
    look("R3", 32'h4000_3ABC, 4'd3, 1'b1,
         want_pa(32'h8000_6000, 32'h4000_3ABC, 2'd1), 4'd9, 1'b0);
    look("R3", 32'h4000_4000, 4'd3, 1'b0, 32'h0, 4'd0, 1'b0);
    wr(1'b1, 5'd5, 32'h5000_0000, 32'h1238_0000, 2'd2, 4'd5, 1'b0, 4'd1);
    look("R3", 32'h5007_FFFC, 4'd5, 1'b1,
         want_pa(32'h1238_0000, 32'h5007_FFFC, 2'd2), 4'd1, 1'b0);
    look("R3", 32'h5008_0000, 4'd5, 1'b0, 32'h0, 4'd0, 1'b0);
    wr(1'b1, 5'd6, 32'h6000_0000, 32'h3480_0000, 2'd3, 4'd6, 1'b0, 4'd14);
    look("R4", 32'h607F_FFF0, 4'd6, 1'b1,
         want_pa(32'h3480_0000, 32'h607F_FFF0, 2'd3), 4'd14, 1'b0);
    look("R3", 32'h6080_0000, 4'd6, 1'b0, 32'h0, 4'd0, 1'b0);
  endtask

  task automatic t_asid();
    look("R5", 32'h1234_5678, 4'd3, 1'b0, 32'h0, 4'd0, 1'b0);
    wr(1'b1, 5'd7, 32'h7000_0000, 32'h0700_0000, 2'd0, 4'd9, 1'b1, 4'd7);
    look("R5", 32'h7000_0010, 4'd1, 1'b1, 32'h0700_0010, 4'd7, 1'b0);
    look("R6", 32'h7000_0020, 4'd9, 1'b1, 32'h0700_0020, 4'd7, 1'b0);
  endtask

  task automatic t_multi();
    wr(1'b1, 5'd12, 32'h9000_0000, 32'h0C00_0000, 2'd0, 4'd4, 1'b0, 4'd12);
    look("R7", 32'h9000_0044, 4'd4, 1'b1, 32'h0C00_0044, 4'd12, 1'b0);
    wr(1'b1, 5'd10, 32'h9000_0000, 32'h0A00_0000, 2'd1, 4'd4, 1'b0, 4'd10);
    look("R7", 32'h9000_0044, 4'd4, 1'b1, 32'h0A00_0044, 4'd10, 1'b1);
  endtask

  task automatic t_inv_one();
    inv(2'd1, 5'd4, 4'd0);
    look("R10", 32'h4000_3ABC, 4'd3, 1'b0, 32'h0, 4'd0, 1'b0);
    look("R10", 32'h5000_0100, 4'd5, 1'b1,
         want_pa(32'h1238_0000, 32'h5000_0100, 2'd2), 4'd1, 1'b0);
  endtask

  task automatic t_inv_asid();
    wr(1'b1, 5'd8, 32'h8800_0000, 32'h0880_0000, 2'd0, 4'd2, 1'b1, 4'd8);
    inv(2'd2, 5'd0, 4'd2);
    look("R11", 32'h1234_5678, 4'd2, 1'b0, 32'h0, 4'd0, 1'b0);
    look("R11", 32'h8800_0004, 4'd2, 1'b1, 32'h0880_0004, 4'd8, 1'b0);
    look("R11", 32'h5000_0200, 4'd5, 1'b1,
         want_pa(32'h1238_0000, 32'h5000_0200, 2'd2), 4'd1, 1'b0);
  endtask

  task automatic t_collide();
    // indexed write dropped by a single-slot invalidate elsewhere
    wr_en = 1'b1; wr_use_idx = 1'b1; wr_idx = 5'd20;
    wr_epn = 20'hD0000; wr_ppn = 20'h0D000; wr_size = 2'd0;
    wr_asid = 4'd1; wr_global = 1'b0; wr_group = 4'd3;
    inv(2'd1, 5'd21, 4'd0);
    wr_en = 1'b0;
    look("R13", 32'hD000_0000, 4'd1, 1'b0, 32'h0, 4'd0, 1'b0);
    // round-robin write dropped by an address-space invalidate
    wr_en = 1'b1; wr_use_idx = 1'b0; wr_epn = 20'hD1000;
    inv(2'd2, 5'd0, 4'd14);
    wr_en = 1'b0;
    look("R13", 32'hD100_0000, 4'd1, 1'b0, 32'h0, 4'd0, 1'b0);
    // lookup in the cycle of the write sees the old table
    lk_valid = 1'b1; lk_ea = 32'hE000_0010; lk_asid = 4'd1;
    wr(1'b1, 5'd22, 32'hE000_0000, 32'h0E00_0000, 2'd0, 4'd1, 1'b0, 4'd6);
    lk_valid = 1'b0;
    chk("R13", "rsp_hit same-cycle", {31'b0, rsp_hit}, 32'd0);
    look("R13", 32'hE000_0010, 4'd1, 1'b1, 32'h0E00_0010, 4'd6, 1'b0);
  endtask

  task automatic t_round_robin();
    wr(1'b0, 5'd31, 32'hA000_0000, 32'h0A0A_0000, 2'd0, 4'd1, 1'b0, 4'd2);
    look("R9", 32'hA000_0000, 4'd1, 1'b1, 32'h0A0A_0000, 4'd2, 1'b0);
    inv(2'd1, 5'd0, 4'd0);
    look("R9", 32'hA000_0000, 4'd1, 1'b0, 32'h0, 4'd0, 1'b0);
    wr(1'b0, 5'd31, 32'hA100_0000, 32'h0A1A_0000, 2'd0, 4'd1, 1'b0, 4'd2);
    inv(2'd1, 5'd1, 4'd0);
    look("R9", 32'hA100_0000, 4'd1, 1'b0, 32'h0, 4'd0, 1'b0);
    for (int i = 2; i < 32; i++) begin
      wr(1'b0, 5'd0, 32'hB000_0000 + (i << 12), 32'h0B00_0000 + (i << 12),
         2'd0, 4'd15, 1'b0, 4'd11);
    end
    look("R9", 32'hB001_F000, 4'd15, 1'b1, 32'h0B01_F000, 4'd11, 1'b0);
    wr(1'b0, 5'd31, 32'hC000_0000, 32'h0C0C_0000, 2'd0, 4'd1, 1'b0, 4'd4);
    look("R9", 32'hC000_0008, 4'd1, 1'b1, 32'h0C0C_0008, 4'd4, 1'b0);
    inv(2'd1, 5'd0, 4'd0);
    look("R9", 32'hC000_0008, 4'd1, 1'b0, 32'h0, 4'd0, 1'b0);
    look("R9", 32'hB001_F000, 4'd15, 1'b1, 32'h0B01_F000, 4'd11, 1'b0);
  endtask

  task automatic t_inv_all();
    inv(2'd3, 5'd0, 4'd0);
    look("R12", 32'hB001_F000, 4'd15, 1'b0, 32'h0, 4'd0, 1'b0);
    look("R12", 32'hB000_2000, 4'd15, 1'b0, 32'h0, 4'd0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_asid();
    t_multi();
    t_inv_one();
    t_inv_asid();
    t_collide();
    t_round_robin();
    t_inv_all();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule